// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block is a post-scale counter. It divides a fast input clock by a factor that can be changed while the clock runs. The factor is given as two separate counts. One sets how many input cycles the output stays high, and the other sets how many it stays low. The sum is the division factor, and the split between the two counts sets the duty cycle.

Two control bits change how the output is formed. The pass-through bit sends the input clock straight to the output, which is a divide by one. The half-cycle bit moves the falling transition from a rising input edge to the falling input edge half a cycle earlier. With an odd factor this gives a 50% duty cycle.

New settings are taken only at the end of an output period. A change made mid-period therefore never cuts a pulse short.

Top module: `pscale_div`

## Requirements
- R1: While rst_ni is low, clk_o is held low and the period counter is cleared. The first rising clk_i edge after reset is released starts a new output period.
- R2: When bypass_i is 0, each output period lasts H+L input cycles, where H is hi_cnt_i and L is lo_cnt_i. clk_o rises on the rising clk_i edge that starts each period. For example, 5/5 gives a divide by 10 at 50% duty.
- R3: When bypass_i is 0 and odd_i is 0, clk_o stays high for exactly H whole input cycles and falls on a rising clk_i edge. For example, 4/6 gives 40/60 duty, and 2/1 gives a divide by 3 with about 67/33 duty.
- R4: When odd_i is 1 (and bypass_i is 0), clk_o falls on the falling clk_i edge inside the last high cycle. The high time becomes H-0.5 cycles and the low time L+0.5 cycles, so 2/1 gives a divide by 3 at 50% duty.
- R5: When bypass_i is 1, clk_o equals clk_i, and hi_cnt_i, lo_cnt_i and odd_i have no effect on the output.
- R6: A count value of 0 on either hi_cnt_i or lo_cnt_i stands for 256 input cycles.
- R7: The settings hi_cnt_i, lo_cnt_i, odd_i and bypass_i are sampled only at the rising edge that starts a period. A change made mid-period first affects the output in the following period.
- R8: A switch into or out of pass-through takes effect only at a period boundary, and it produces no shortened pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cnt_i | input | 8 | High-time count in input cycles (0 means 256) |
| lo_cnt_i | input | 8 | Low-time count in input cycles (0 means 256) |
| bypass_i | input | 1 | 1 passes clk_i straight to the output |
| odd_i | input | 1 | 1 moves the falling edge half a cycle earlier |
| clk_o | output | 1 | Divided clock |

## Verification
The assertions check on every cycle that the position counter stays inside the current period and that the output rises only at position zero. They also check that, in normal mode, the output falls only when the counter reaches the high count, that the output stays high through every high cycle in normal mode, and that it is already low at the end of the last high cycle in half-cycle mode. A further assertion checks that the stored settings never change except at a period boundary.

Only the bench scenarios can show the output waveform itself. The bench samples both halves of every input cycle against a model of the period. This covers the exact duty ratios, the 256-cycle meaning of a zero count, the delay of mid-period setting changes, and clean entry into and exit from pass-through.

// File: rtl/pscale_pkg.sv
package pscale_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_ODD  = 2'd1,
    MODE_BYP  = 2'd2
  } mode_e;

  function automatic mode_e mode_of(input logic byp, input logic odd);
    if (byp) return MODE_BYP;
    if (odd) return MODE_ODD;
    return MODE_NORM;
  endfunction
endpackage

// File: rtl/pscale_cfg.sv
module pscale_cfg
  import pscale_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PER_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic             bypass_i,
  input  logic             odd_i,
  output logic [PER_W-1:0] hi_q_o,
  output logic [PER_W-1:0] hi_nxt_o,
  output logic [PER_W-1:0] last_q_o,
  output mode_e            mode_q_o,
  output mode_e            mode_nxt_o
);
  localparam int unsigned FULL = 2 ** CNT_W;

  logic [PER_W-1:0] hi_in, lo_in, last_in;
  logic [PER_W-1:0] hi_q, lo_q, last_q;
  mode_e            mode_in, mode_q;

  // zero count stands for the full range
  always_comb begin
    hi_in   = (hi_cnt_i == '0) ? PER_W'(FULL) : PER_W'(hi_cnt_i);
    lo_in   = (lo_cnt_i == '0) ? PER_W'(FULL) : PER_W'(lo_cnt_i);
    last_in = hi_in + lo_in - PER_W'(1);
    mode_in = mode_of(bypass_i, odd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= PER_W'(1);
      lo_q   <= PER_W'(1);
      last_q <= PER_W'(1);
      mode_q <= MODE_NORM;
    end else if (load_i) begin
      hi_q   <= hi_in;
      lo_q   <= lo_in;
      last_q <= last_in;
      mode_q <= mode_in;
    end
  end

  assign hi_q_o     = hi_q;
  assign last_q_o   = last_q;
  assign mode_q_o   = mode_q;
  assign hi_nxt_o   = load_i ? hi_in : hi_q;
  assign mode_nxt_o = load_i ? mode_in : mode_q;

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(mode_q)));
endmodule

// File: rtl/pscale_cnt.sv
module pscale_cnt
  import pscale_pkg::*;
#(
  parameter int unsigned PER_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] hi_cur_i,
  input  logic [PER_W-1:0] hi_nxt_i,
  input  logic [PER_W-1:0] last_i,
  input  mode_e            mode_i,
  input  mode_e            mode_nxt_i,
  output logic             load_o,
  output logic             hi_o,
  output logic             last_hi_o
);
  logic             run_q, hi_q, last_hi_q;
  logic [PER_W-1:0] cnt_q, cnt_n;

  // period boundary: first edge after reset, every edge in bypass, or end of period
  assign load_o = !run_q || (mode_i == MODE_BYP) || (cnt_q == last_i);
  assign cnt_n  = load_o ? '0 : cnt_q + PER_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      hi_q      <= 1'b0;
      last_hi_q <= 1'b0;
    end else begin
      run_q     <= 1'b1;
      cnt_q     <= cnt_n;
      hi_q      <= (mode_nxt_i != MODE_BYP) && (cnt_n < hi_nxt_i);
      last_hi_q <= (mode_nxt_i == MODE_ODD) && (cnt_n == hi_nxt_i - PER_W'(1));
    end
  end

  assign hi_o      = hi_q;
  assign last_hi_o = last_hi_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
  // R2
  rise_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> (cnt_q == '0));
  // R3
  fall_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hi_q) && mode_i != MODE_BYP) |-> (cnt_q == hi_cur_i));
endmodule

// File: rtl/pscale_half.sv
module pscale_half (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_hi_i,
  output logic drop_o
);
  logic drop_q;

  // falling-edge stage: pulls the output low half a cycle early
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= last_hi_i;
  end

  assign drop_o = drop_q;
endmodule

// File: rtl/pscale_div.sv
module pscale_div
  import pscale_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic             bypass_i,
  input  logic             odd_i,
  output logic             clk_o
);
  localparam int unsigned PER_W = CNT_W + 2;

  logic [PER_W-1:0] hi_q, hi_nxt, last_q;
  mode_e            mode_q, mode_nxt;
  logic             load, hi_w, last_hi, drop, div_w;

  pscale_cfg #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .hi_cnt_i   (hi_cnt_i),
    .lo_cnt_i   (lo_cnt_i),
    .bypass_i   (bypass_i),
    .odd_i      (odd_i),
    .hi_q_o     (hi_q),
    .hi_nxt_o   (hi_nxt),
    .last_q_o   (last_q),
    .mode_q_o   (mode_q),
    .mode_nxt_o (mode_nxt)
  );

  pscale_cnt #(.PER_W(PER_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_cur_i   (hi_q),
    .hi_nxt_i   (hi_nxt),
    .last_i     (last_q),
    .mode_i     (mode_q),
    .mode_nxt_i (mode_nxt),
    .load_o     (load),
    .hi_o       (hi_w),
    .last_hi_o  (last_hi)
  );

  pscale_half u_half (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_hi_i (last_hi),
    .drop_o    (drop)
  );

  // drop only overlaps the tail of the high phase, so the AND cannot glitch high
  assign div_w = hi_w & ~drop;
  assign clk_o = (mode_q == MODE_BYP) ? clk_i : div_w;

  // R1
  always_comb begin
    if (!rst_ni) begin
      rst_low_chk: assert (clk_o == 1'b0);
    end
  end
  // R3
  norm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NORM && hi_w) |-> div_w);
  // R4
  odd_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_hi |-> !div_w);
endmodule

// File: tb/tb_pscale_div.sv
module tb_pscale_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [7:0] hi_cnt_i = 8'd1;
  logic [7:0] lo_cnt_i = 8'd1;
  logic       bypass_i = 1'b0;
  logic       odd_i = 1'b0;
  logic       clk_o;

  pscale_div dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hi_cnt_i(hi_cnt_i), .lo_cnt_i(lo_cnt_i),
    .bypass_i(bypass_i), .odd_i(odd_i), .clk_o(clk_o)
  );

  always #2 clk_i = ~clk_i; // 250 MHz

  typedef struct {
    bit    first;
    bit    second;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  string scen = "";
  bit    done = 0;

  // reference period model, one expected item per input cycle
  int pos = 0, a_h = 1, plen = 2;
  bit a_byp = 0, a_odd = 0, run = 0;

  always @(posedge clk_i) begin
    exp_t e;
    if (!rst_ni) begin
      run = 0;
      e.first = 0; e.second = 0; e.req = "R1";
    end else begin
      if (!run || a_byp || pos == plen - 1) begin
        a_h   = (hi_cnt_i == 0) ? 256 : int'(hi_cnt_i);
        plen  = a_h + ((lo_cnt_i == 0) ? 256 : int'(lo_cnt_i));
        a_byp = bypass_i;
        a_odd = odd_i;
        pos   = 0;
        run   = 1;
      end else begin
        pos++;
      end
      if (a_byp) begin
        e.first = 1; e.second = 0;
      end else begin
        e.first  = (pos < a_h);
        e.second = a_odd ? (pos < a_h - 1) : (pos < a_h);
      end
      if (scen != "")  e.req = scen;
      else if (a_byp)  e.req = "R5";
      else if (a_odd)  e.req = "R4";
      else             e.req = "R2";
    end
    sb_q.push_back(e);
  end

  task automatic check(input bit act, input bit exp_v, input string req, input string half);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s clk_o %s half at %0t: actual %0b expected %0b", req, half, $time, act, exp_v);
    end
  endtask

  // monitor: pops one item per cycle and compares both halves
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(clk_o, e.first, e.req, "first");
        #2;
        check(clk_o, e.second, e.req, "second");
      end
    end
  end

  task automatic apply(input int h, input int l, input bit b, input bit o,
                       input int ncyc, input string req);
    @(posedge clk_i);
    #1;
    hi_cnt_i = 8'(h);
    lo_cnt_i = 8'(l);
    bypass_i = b;
    odd_i    = o;
    scen     = req;
    repeat (ncyc) @(posedge clk_i);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    // R1: output low and counters cleared during reset
    #10 rst_ni = 1'b1;
    apply(5, 5, 0, 0, 30, "R2");     // divide by 10, 50%
    apply(4, 6, 0, 0, 30, "R3");     // 40/60
    apply(2, 1, 0, 0, 12, "R3");     // divide by 3, ~67/33
    apply(2, 1, 0, 1, 12, "R4");     // divide by 3, 50%
    apply(3, 4, 0, 1, 21, "R4");
    apply(1, 2, 0, 1, 12, "R4");
    apply(3, 3, 0, 0, 2, "R7");      // mid-period change
    apply(7, 1, 0, 0, 20, "R7");
    apply(2, 2, 1, 0, 6, "R8");      // enter pass-through at a boundary
    apply(9, 0, 1, 1, 5, "R5");      // counts and odd bit ignored
    apply(0, 3, 1, 0, 5, "R5");
    apply(3, 2, 0, 0, 12, "R8");     // leave pass-through
    apply(3, 2, 1, 0, 8, "R8");
    apply(0, 1, 0, 0, 560, "R6");    // 256 high + 1 low
    apply(1, 0, 0, 1, 300, "R6");    // 1 high + 256 low, odd
    #1 rst_ni = 1'b0;
    apply(5, 5, 0, 0, 3, "R1");
    #4;
    done = 1;
    finish_run();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule